// File: doc/BRIEF.md
# Addressable LED Strip Register Front End

This block is the software-facing side of a serial addressable-LED transmitter. A 32-bit register bus programs the pixel count, colour-order mode and start bit of a frame, holds two raw timing words for the waveform generator, and accepts pixel words through a data port that feeds a 32-entry FIFO. The waveform generator takes words from the FIFO with a valid/ready pair and reports the end of a frame, including its trailing reset gap, with a one-cycle `frame_done` pulse.

Software keeps the FIFO fed in one of two ways. In the first, a DMA request output is raised while there is room for a programmed burst. In the second, a CPU-request interrupt flag is raised when the fill level drops below that same threshold. A transfer-finished flag marks the end of each frame. Both flags are write-one-to-clear. The current FIFO fill level is visible in the status word, so an interrupt handler can size its next burst from a single read.

Top module: `ledstrip_regif`

## Requirements
- R1: After reset every register reads zero, the FIFO is empty, and `irq`, `dma_req` and `pix_valid` are low.
- R2: Offset 0x00 keeps the pixel count in bits 28:16, the colour order in bits 6..8 and the enable in bit 0. Offsets 0x04 and 0x0C are full 32-bit words that read back and drive `bit_timing` and `gap_timing`. Offset 0x18 keeps the trigger level in bits 4:0 and the DMA enable in bit 5. Offset 0x1C keeps the finished enable in bit 0, the CPU-request enable in bit 1 and the global enable in bit 5. Unused bits and unmapped offsets read zero.
- R3: A write to offset 0x14 pushes one word into the FIFO unless the FIFO holds 32 words, in which case the word is dropped. A read of 0x14 returns zero. The fill level (0..32) reads in status bits 15:10 at offset 0x20.
- R4: `pix_valid` is high exactly while the FIFO is not empty. `pix_data` shows the oldest word. A word is removed on each cycle where `pix_valid` and `pix_ready` are both high.
- R5: Writing offset 0x00 with bit 0 set while the enable is clear starts a transfer and empties the FIFO. The enable bit then reads 1.
- R6: A `frame_done` pulse while the enable is set clears the enable and sets the finished flag (status bit 0). A pulse while the enable is clear has no effect.
- R7: The CPU-request flag (status bit 1) sets on every cycle in which the enable is set, DMA is disabled and the fill level is below the trigger level.
- R8: Writing 1 to status bit 0 or bit 1 clears that flag. If the set condition holds in the same cycle, the set wins.
- R9: `dma_req` is high when the DMA enable is set and the free space (32 minus the level) is at least the trigger level.
- R10: `irq` is the global enable ANDed with the OR of each flag gated by its own enable.
- R11: A push and a pop in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for the write or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_done | input | 1 | Pulse from the generator at the end of a frame |
| pix_ready | input | 1 | Generator takes the head word |
| pix_valid | output | 1 | FIFO holds at least one word |
| pix_data | output | 32 | Oldest FIFO word |
| tx_enable | output | 1 | Transfer active |
| px_count | output | 13 | Programmed pixel count |
| color_order | output | 3 | Programmed colour-order mode |
| bit_timing | output | 32 | Raw bit-timing word |
| gap_timing | output | 32 | Raw reset-gap word |
| dma_req | output | 1 | Refill request for a DMA engine |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of events can fall in the same cycle. First, a `frame_done` pulse can coincide with a write-one-to-clear of the finished flag. The bench drives both on the same edge and expects the flag to remain set and `irq` to stay high; a later clear on its own then drops them. Second, the generator can take a word in the cycle where the bus pushes one. The bench raises `pix_ready` together with a data-port write and expects the reported level to stay unchanged, with the oldest word leaving first. The CPU-request level condition is also probed by clearing the flag while the condition still holds and expecting it to remain set.

// File: rtl/ledstrip_regif_pkg.sv
package ledstrip_regif_pkg;
   localparam int ADDR_W = 8;
   localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_BITT  = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_GAPT  = 8'h0C;
   localparam logic [ADDR_W-1:0] OFF_DATA  = 8'h14;
   localparam logic [ADDR_W-1:0] OFF_DMA   = 8'h18;
   localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h1C;
   localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h20;
   // field positions decoded by software
   localparam int CNT_POS   = 16;
   localparam int MODE_POS  = 6;
   localparam int DMAEN_BIT = 5;
   localparam int GIE_BIT   = 5;
   localparam int LVL_POS   = 10;
   localparam int NSRC      = 2;  // 0: finished, 1: cpu request
endpackage

// File: rtl/ledstrip_pixfifo.sv
module ledstrip_pixfifo #(
   parameter int DEPTH = 32,
   parameter int W     = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   output logic [LVL_W-1:0] level
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wnext, rnext;
   logic             do_push, do_pop;

   assign do_push = push && (level != LVL_W'(DEPTH));
   assign do_pop  = pop && (level != '0);
   assign rdata   = mem[rptr];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_mod
         assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
      end
   end
endmodule

// File: rtl/ledstrip_irqflags.sv
module ledstrip_irqflags #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] en,
   input  logic            gie,
   output logic [NSRC-1:0] flags,
   output logic            irq
);
   logic [NSRC-1:0] gated;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;  // set beats clear
            else if (clr[i]) flags[i] <= 1'b0;
         end
         assign gated[i] = flags[i] & en[i];
      end
   endgenerate

   assign irq = gie & (|gated);
endmodule

// File: rtl/ledstrip_regif.sv
module ledstrip_regif
   import ledstrip_regif_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int CNT_W  = 13,
   parameter int MODE_W = 3,
   localparam int TRIG_W = $clog2(DEPTH),
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              frame_done,
   input  logic              pix_ready,
   output logic              pix_valid,
   output logic [31:0]       pix_data,
   output logic              tx_enable,
   output logic [CNT_W-1:0]  px_count,
   output logic [MODE_W-1:0] color_order,
   output logic [31:0]       bit_timing,
   output logic [31:0]       gap_timing,
   output logic              dma_req,
   output logic              irq
);
   generate
      if (CNT_W > 13)        begin : g_bad_cnt  $error("CNT_W exceeds its field"); end
      if (MODE_W > 3)        begin : g_bad_mode $error("MODE_W exceeds its field"); end
      if (TRIG_W > DMAEN_BIT) begin : g_bad_trig $error("DEPTH too large for trigger field"); end
      if (LVL_W > 6)         begin : g_bad_lvl  $error("DEPTH too large for level field"); end
   endgenerate

   logic wr_ctrl, wr_bitt, wr_gapt, wr_data, wr_dma, wr_ien, wr_stat;
   assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
   assign wr_bitt = bus_wr && (bus_addr == OFF_BITT);
   assign wr_gapt = bus_wr && (bus_addr == OFF_GAPT);
   assign wr_data = bus_wr && (bus_addr == OFF_DATA);
   assign wr_dma  = bus_wr && (bus_addr == OFF_DMA);
   assign wr_ien  = bus_wr && (bus_addr == OFF_IEN);
   assign wr_stat = bus_wr && (bus_addr == OFF_STAT);

   logic              act_q, dma_en_q, gie_q;
   logic [TRIG_W-1:0] trig_q;
   logic [NSRC-1:0]   ien_q, flags, set_v, clr_v;
   logic [LVL_W-1:0]  level, room, trig_ext;
   logic              start, pop;

   assign start = wr_ctrl && bus_wdata[0] && !act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         px_count    <= '0;
         color_order <= '0;
         bit_timing  <= '0;
         gap_timing  <= '0;
         dma_en_q    <= 1'b0;
         trig_q      <= '0;
         gie_q       <= 1'b0;
         ien_q       <= '0;
      end else begin
         if (wr_ctrl) begin
            act_q       <= bus_wdata[0];
            px_count    <= bus_wdata[CNT_POS +: CNT_W];
            color_order <= bus_wdata[MODE_POS +: MODE_W];
         end else if (frame_done && act_q) begin
            act_q <= 1'b0;
         end
         if (wr_bitt) bit_timing <= bus_wdata;
         if (wr_gapt) gap_timing <= bus_wdata;
         if (wr_dma) begin
            dma_en_q <= bus_wdata[DMAEN_BIT];
            trig_q   <= bus_wdata[TRIG_W-1:0];
         end
         if (wr_ien) begin
            gie_q <= bus_wdata[GIE_BIT];
            ien_q <= bus_wdata[NSRC-1:0];
         end
      end
   end

   assign tx_enable = act_q;

   ledstrip_pixfifo #(.DEPTH(DEPTH), .W(32)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (start),
      .push  (wr_data),
      .pop   (pop),
      .wdata (bus_wdata),
      .rdata (pix_data),
      .level (level)
   );

   assign pix_valid = (level != '0);
   assign pop       = pix_valid && pix_ready;

   assign trig_ext = {{(LVL_W-TRIG_W){1'b0}}, trig_q};
   assign room     = LVL_W'(DEPTH) - level;
   assign dma_req  = dma_en_q && (room >= trig_ext);

   assign set_v[0] = frame_done && act_q;
   assign set_v[1] = act_q && !dma_en_q && (level < trig_ext);
   assign clr_v    = wr_stat ? bus_wdata[NSRC-1:0] : '0;

   ledstrip_irqflags #(.NSRC(NSRC)) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v),
      .clr   (clr_v),
      .en    (ien_q),
      .gie   (gie_q),
      .flags (flags),
      .irq   (irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFF_CTRL: begin
            bus_rdata[CNT_POS +: CNT_W]   = px_count;
            bus_rdata[MODE_POS +: MODE_W] = color_order;
            bus_rdata[0]                  = act_q;
         end
         OFF_BITT: bus_rdata = bit_timing;
         OFF_GAPT: bus_rdata = gap_timing;
         OFF_DMA: begin
            bus_rdata[DMAEN_BIT]    = dma_en_q;
            bus_rdata[TRIG_W-1:0]   = trig_q;
         end
         OFF_IEN: begin
            bus_rdata[GIE_BIT]      = gie_q;
            bus_rdata[NSRC-1:0]     = ien_q;
         end
         OFF_STAT: begin
            bus_rdata[LVL_POS +: LVL_W] = level;
            bus_rdata[NSRC-1:0]         = flags;
         end
         default: bus_rdata = '0;
      endcase
   end

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/ledstrip_regif_chk.sv
module ledstrip_regif_chk #(
   parameter int DEPTH = 32,
   parameter int LVL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] level,
   input logic             push,
   input logic             pop,
   input logic             start,
   input logic             wr_ctrl,
   input logic             frame_done,
   input logic             act,
   input logic             fin_flag,
   input logic             gie,
   input logic             irq,
   input logic             dma_en,
   input logic             dma_req,
   input logic             pix_valid
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));  // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !start && level == LVL_W'(DEPTH)) |=> (level == LVL_W'(DEPTH)));  // R3
   AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid == (level != '0));  // R4
   AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (level == '0));  // R5
   AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && act) |=> fin_flag);  // R8
   AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && act && !wr_ctrl) |=> !act);  // R6
   AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !dma_req);  // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq);  // R10
   AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !start && level != '0 && level != LVL_W'(DEPTH)) |=> $stable(level));  // R11
endmodule

bind ledstrip_regif ledstrip_regif_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .level      (level),
   .push       (wr_data),
   .pop        (pop),
   .start      (start),
   .wr_ctrl    (wr_ctrl),
   .frame_done (frame_done),
   .act        (act_q),
   .fin_flag   (flags[0]),
   .gie        (gie_q),
   .irq        (irq),
   .dma_en     (dma_en_q),
   .dma_req    (dma_req),
   .pix_valid  (pix_valid)
);

// File: tb/ledstrip_regif_tb.sv
module ledstrip_regif_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;
   // {offset, write data, expected readback}
   localparam logic [71:0] VEC [NVEC] = '{
      {8'h00, 32'hFFFF_FFFE, 32'h1FFF_01C0},
      {8'h00, 32'h0000_0000, 32'h0000_0000},
      {8'h04, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
      {8'h0C, 32'h0123_4567, 32'h0123_4567},
      {8'h18, 32'hFFFF_FFC0, 32'h0000_0000},
      {8'h18, 32'h0000_0035, 32'h0000_0035},
      {8'h18, 32'h0000_0000, 32'h0000_0000},
      {8'h1C, 32'hFFFF_FFDC, 32'h0000_0000},
      {8'h1C, 32'h0000_0023, 32'h0000_0023},
      {8'h1C, 32'h0000_0000, 32'h0000_0000},
      {8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h24, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        frame_done = 1'b0, pix_ready = 1'b0;
   logic        pix_valid, tx_enable, dma_req, irq;
   logic [31:0] pix_data, bit_timing, gap_timing;
   logic [12:0] px_count;
   logic [2:0]  color_order;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;
   logic [31:0] rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   ledstrip_regif dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
      .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_data(pix_data),
      .tx_enable(tx_enable), .px_count(px_count), .color_order(color_order),
      .bit_timing(bit_timing), .gap_timing(gap_timing), .dma_req(dma_req), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic take(output logic [31:0] d);
      @(negedge clk);
      pix_ready = 1'b1;
      #1 d = pix_data;
      @(negedge clk);
      pix_ready = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rdreg(8'h20, rd); chk("R1 status", rd, 32'h0);
      rdreg(8'h00, rd); chk("R1 ctrl", rd, 32'h0);
      chk("R1 outputs", {29'h0, irq, dma_req, pix_valid}, 32'h0);

      // R2 register table
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][71:64], VEC[i][63:32]);
         rdreg(VEC[i][71:64], rd);
         chk($sformatf("R2 vec%0d", i), rd, VEC[i][31:0]);
      end
      chk("R2 bit_timing", bit_timing, 32'hA5A5_5A5A);
      chk("R2 gap_timing", gap_timing, 32'h0123_4567);

      // R5 start: count 5, order 2, enable
      wr(8'h00, 32'h0005_0081);
      rdreg(8'h00, rd); chk("R5 ctrl", rd, 32'h0005_0081);
      chk("R2 outputs", {16'h0, tx_enable, color_order, px_count}, {16'h0, 1'b1, 3'd2, 13'd5});

      // R3 push, R4 ordered pop
      wr(8'h14, 32'hA);
      wr(8'h14, 32'hB);
      wr(8'h14, 32'hC);
      rdreg(8'h20, rd); chk("R3 level 3", rd, 32'h0000_0C00);
      rdreg(8'h14, rd); chk("R3 data reads zero", rd, 32'h0);
      chk("R4 valid", {31'h0, pix_valid}, 32'h1);
      take(rd); chk("R4 first word", rd, 32'hA);
      take(rd); chk("R4 second word", rd, 32'hB);

      // R7 cpu request: level 1 below trigger 4
      wr(8'h18, 32'h0000_0004);
      idle();
      rdreg(8'h20, rd); chk("R7 cpureq set", rd, 32'h0000_0402);
      chk("R10 no irq without enable", {31'h0, irq}, 32'h0);
      wr(8'h1C, 32'h0000_0022);
      chk("R10 irq", {31'h0, irq}, 32'h1);
      wr(8'h1C, 32'h0000_0002);
      chk("R10 gie gates", {31'h0, irq}, 32'h0);
      wr(8'h1C, 32'h0000_0022);
      wr(8'h20, 32'h0000_0002);
      rdreg(8'h20, rd); chk("R7 condition reasserts", rd, 32'h0000_0402);
      wr(8'h18, 32'h0000_0000);
      wr(8'h20, 32'h0000_0002);
      rdreg(8'h20, rd); chk("R8 W1C clears", rd, 32'h0000_0400);
      chk("R10 irq drops", {31'h0, irq}, 32'h0);

      // R3 fill to 32 and drop one
      for (int k = 0; k < 31; k++) wr(8'h14, 32'hD00 + k);
      rdreg(8'h20, rd); chk("R3 full", rd, 32'h0000_8000);
      wr(8'h14, 32'hDEAD);
      rdreg(8'h20, rd); chk("R3 drop when full", rd, 32'h0000_8000);
      take(rd); chk("R4 C after fill", rd, 32'hC);
      take(rd); chk("R4 D0", rd, 32'hD00);
      rdreg(8'h20, rd); chk("R3 level 30", rd, 32'h0000_7800);

      // R11 push and pop together
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'hE0; pix_ready = 1'b1;
      #1 chk("R11 head during overlap", pix_data, 32'hD01);
      @(negedge clk);
      bus_wr = 1'b0; pix_ready = 1'b0;
      rdreg(8'h20, rd); chk("R11 level kept", rd, 32'h0000_7800);

      // R9 dma request
      wr(8'h18, 32'h0000_0022);
      chk("R9 room equals trigger", {31'h0, dma_req}, 32'h1);
      wr(8'h18, 32'h0000_0023);
      chk("R9 room below trigger", {31'h0, dma_req}, 32'h0);
      wr(8'h18, 32'h0000_003F);
      idle();
      rdreg(8'h20, rd); chk("R7 no cpureq with dma", rd, 32'h0000_7800);
      wr(8'h18, 32'h0000_0000);

      // R6 frame end
      wr(8'h1C, 32'h0000_0021);
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      rdreg(8'h00, rd); chk("R6 enable cleared", rd, 32'h0005_0080);
      rdreg(8'h20, rd); chk("R6 finished flag", rd, 32'h0000_7801);
      chk("R10 finished irq", {31'h0, irq}, 32'h1);

      // R5 restart flushes
      wr(8'h00, 32'h0005_0081);
      rdreg(8'h20, rd); chk("R5 flushed", rd, 32'h0000_0001);
      chk("R5 valid low", {31'h0, pix_valid}, 32'h0);

      // R8 set wins over clear
      @(negedge clk);
      frame_done = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
      @(negedge clk);
      frame_done = 1'b0; bus_wr = 1'b0;
      rdreg(8'h20, rd); chk("R8 set wins", rd, 32'h0000_0001);
      chk("R8 irq stays", {31'h0, irq}, 32'h1);
      wr(8'h20, 32'h0000_0001);
      rdreg(8'h20, rd); chk("R8 clear alone", rd, 32'h0);

      // R6 pulse while idle ignored
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      rdreg(8'h20, rd); chk("R6 idle pulse ignored", rd, 32'h0);
      chk("R6 irq quiet", {31'h0, irq}, 32'h0);

      finish_run();
   end
endmodule